// File: doc/BRIEF.md
# Eight-Channel Serial FIFO Bus Port

This block is the host-side access logic for the receive and transmit byte queues of eight serial channels. A 32-bit request/acknowledge bus reaches each channel through three address regions. The first is a multi-byte queue window, which moves as many bytes per access as there are enabled byte lanes. The second is a paired window, which returns each received byte next to its error flags. The third is a legacy region that holds a one-byte holding register and a line-status word. The line side pushes received bytes with their error bits into the receive queues and pops transmit bytes from the transmit queues, one per cycle.

Bus control is a two-state machine. ST_IDLE accepts a request: the pops, pushes and read data are all worked out in that cycle, and the transition IDLE->ACK is taken. ST_ACK drives the acknowledge with the registered read data, and the transition ACK->IDLE is always taken on the next clock. A request that is presented while ST_ACK is active is ignored.

Top module: `uart_fifo_port`

## Requirements
- R1: Address decoding works as follows. The channel is addr[12:10]. Address bits above bit 12 must be zero. Within a channel, addr[9:8]=01 is the queue window and addr[9:8]=10 or 11 is the paired window. With addr[9:8]=00, offset 0x000 is the holding register and offset 0x004 is the line-status word.
- R2: A read of the queue window pops one received byte for each enabled lane. Bytes are placed oldest first into the enabled lanes in ascending lane order. The next read continues with the following byte.
- R3: A write to the queue window pushes the enabled lanes' bytes in ascending lane order. The line side then pops them in that same order.
- R4: A read of the paired window returns, for each half-word with any lane enabled, a 16-bit pair with data in bits 7:0 and status in bits 15:8. The oldest pair goes in the lower enabled half. The status bits are: bit0=1, bit1 parity error, bit2 framing error, bit3 break, and bits 7:4 are zero.
- R5: When the receive queue holds fewer bytes than are requested, the lanes or halves that cannot be filled read 0x00 and pop nothing.
- R6: Transmit bytes that arrive at a full 64-entry queue are dropped, and a sticky overflow flag is set. The flag reads as bit 7 of the line-status word, and reading that word clears it.
- R7: A read of the holding register with lane 0 enabled pops one byte into bits 7:0. A write with lane 0 enabled pushes wdata[7:0]. Lanes 1 to 3 are ignored. Without lane 0, the access does nothing.
- R8: The line-status word gives bit0 = receive queue not empty and bits 3:1 = {break, framing, parity} of the oldest byte (zero when the queue is empty). Reading it pops nothing.
- R9: The acknowledge is high for exactly one cycle, in the cycle after an accepted request. Read data is valid with the acknowledge and is zero for writes.
- R10: Unmapped addresses read zero, and writes to them are ignored. Writes to the paired window and to the line-status word are ignored.
- R11: An access to one channel never changes another channel's queues or flag.
- R12: Each receive queue holds 64 entries. A byte pushed from the line side into a full receive queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access request, accepted in ST_IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after accept |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| rx_in_vld | input | 1 | Line side pushes a received byte |
| rx_in_ch | input | 3 | Channel of the received byte |
| rx_in_data | input | 8 | Received byte |
| rx_in_err | input | 3 | {break, framing, parity} of the byte |
| tx_out_ch | input | 3 | Channel whose transmit head is shown |
| tx_out_rdy | input | 1 | Line side pops the shown byte |
| tx_out_vld | output | 1 | Selected transmit queue not empty |
| tx_out_data | output | 8 | Oldest byte of selected transmit queue |

## Verification
The bench sweeps all fifteen lane-enable patterns against receive queues that run dry partway through. A design that packed lanes out of order, skipped disabled lanes wrongly, or popped bytes for empty lanes would hand back bytes shifted or lost on the following read. Paired-window reads are checked for pair order and for the status bit layout. Holding reads without lane 0 and line-status reads are checked to pop nothing. Overflowing a transmit queue must drop the tail, set the flag, and clear it on the following status read. A design that overwrote the oldest bytes or cleared the flag early would show up in the drained order or in the flag value. Unmapped and read-only writes must leave every queue untouched.

// File: rtl/uart_fifo_port_pkg.sv
package uart_fifo_port_pkg;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_FIFO,
        WIN_PAIR,
        WIN_HOLD,
        WIN_LSR
    } win_e;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } bus_st_e;

    // err is {break, framing, parity}
    function automatic logic [7:0] pair_status(input logic [2:0] err);
        return {4'b0000, err, 1'b1};
    endfunction

endpackage

// File: rtl/uart_fifo_addr_dec.sv
module uart_fifo_addr_dec
    import uart_fifo_port_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CH_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [CH_W-1:0]   ch
);
    localparam int HI = CH_W + 10;

    logic hi_set;

    generate
        if (ADDR_W > HI) begin : g_hi
            assign hi_set = |addr[ADDR_W-1:HI];
        end else begin : g_nohi
            assign hi_set = 1'b0;
        end
    endgenerate

    assign ch = addr[HI-1:10];

    always_comb begin
        win = WIN_NONE;
        if (!hi_set) begin
            unique case (addr[9:8])
                2'b00: begin
                    if (addr[7:0] == 8'h00)      win = WIN_HOLD;
                    else if (addr[7:0] == 8'h04) win = WIN_LSR;
                end
                2'b01:   win = WIN_FIFO;
                default: win = WIN_PAIR;
            endcase
        end
    end
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int W          = 8,
    parameter int DEPTH      = 64,
    parameter int PUSH_LANES = 4,
    parameter int POP_LANES  = 1,
    localparam int AW  = $clog2(DEPTH),
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int PNW = $clog2(PUSH_LANES + 1),
    localparam int QNW = $clog2(POP_LANES + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PNW-1:0]                 push_n,
    input  logic [PUSH_LANES-1:0][W-1:0]   push_data,
    input  logic [QNW-1:0]                 pop_n,
    output logic [POP_LANES-1:0][W-1:0]    head,
    output logic [CW-1:0]                  count
);
    logic [W-1:0]   mem [DEPTH];
    logic [AW-1:0]  wr_q, rd_q;
    logic [CW-1:0]  free;
    logic [PNW-1:0] acc_push;
    logic [QNW-1:0] acc_pop;

    assign free     = CW'(DEPTH) - count;
    assign acc_push = (CW'(push_n) <= free)  ? push_n : PNW'(free);
    assign acc_pop  = (CW'(pop_n)  <= count) ? pop_n  : QNW'(count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            wr_q  <= wr_q + AW'(acc_push);
            rd_q  <= rd_q + AW'(acc_pop);
            count <= count + CW'(acc_push) - CW'(acc_pop);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_LANES; i++) begin
            if (PNW'(i) < acc_push) mem[wr_q + AW'(i)] <= push_data[i];
        end
    end

    always_comb begin
        for (int i = 0; i < POP_LANES; i++) head[i] = mem[rd_q + AW'(i)];
    end
endmodule

// File: rtl/uart_fifo_port.sv
module uart_fifo_port
    import uart_fifo_port_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 16,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic [31:0]       bus_rdata,
    input  logic              rx_in_vld,
    input  logic [CH_W-1:0]   rx_in_ch,
    input  logic [7:0]        rx_in_data,
    input  logic [2:0]        rx_in_err,
    input  logic [CH_W-1:0]   tx_out_ch,
    input  logic              tx_out_rdy,
    output logic              tx_out_vld,
    output logic [7:0]        tx_out_data
);
    localparam int LANES = 4;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int RXW   = 11;
    localparam int BNW   = $clog2(LANES + 1);

    bus_st_e st_q, st_d;
    win_e    win;
    logic [CH_W-1:0] ch_sel;
    logic            accept;

    logic [LANES-1:0][RXW-1:0] rx_head [NCH];
    logic [0:0][7:0]           tx_head [NCH];
    logic [CW-1:0]             rx_cnt  [NCH];
    logic [CW-1:0]             tx_cnt  [NCH];
    logic [NCH-1:0]            ovf_q;

    logic [LANES-1:0][RXW-1:0] sel_head;
    logic [CW-1:0]             sel_rx_cnt, sel_tx_free;
    logic [31:0]               rd_d;
    logic [BNW-1:0]            rx_pop_n, tx_push_n, k;
    logic [LANES-1:0][7:0]     tx_push_data;
    logic                      ovf_set, ovf_clr;

    uart_fifo_addr_dec #(.ADDR_W(ADDR_W), .CH_W(CH_W)) dec_i (
        .addr (bus_addr),
        .win  (win),
        .ch   (ch_sel)
    );

    assign accept  = (st_q == ST_IDLE) && bus_req;
    assign bus_ack = (st_q == ST_ACK);

    always_comb begin : next_state
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (bus_req) st_d = ST_ACK;
            ST_ACK:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            bus_rdata <= '0;
        end else begin
            st_q <= st_d;
            if (accept) bus_rdata <= bus_we ? 32'h0 : rd_d;
        end
    end

    always_comb begin : bus_datapath
        rd_d         = '0;
        rx_pop_n     = '0;
        tx_push_n    = '0;
        tx_push_data = '0;
        ovf_set      = 1'b0;
        ovf_clr      = 1'b0;
        k            = '0;
        sel_head     = rx_head[ch_sel];
        sel_rx_cnt   = rx_cnt[ch_sel];
        sel_tx_free  = CW'(DEPTH) - tx_cnt[ch_sel];
        if (accept) begin
            unique case (win)
                WIN_FIFO: begin
                    for (int l = 0; l < LANES; l++) begin
                        if (bus_be[l]) begin
                            if (bus_we) begin
                                tx_push_data[k[1:0]] = bus_wdata[8*l +: 8];
                                k = k + BNW'(1);
                            end else if (CW'(k) < sel_rx_cnt) begin
                                rd_d[8*l +: 8] = sel_head[k[1:0]][7:0];
                                k = k + BNW'(1);
                            end
                        end
                    end
                    if (bus_we) begin
                        tx_push_n = k;
                        ovf_set   = CW'(k) > sel_tx_free;
                    end else begin
                        rx_pop_n = k;
                    end
                end
                WIN_PAIR: if (!bus_we) begin
                    for (int h = 0; h < 2; h++) begin
                        if (|bus_be[2*h +: 2] && (CW'(k) < sel_rx_cnt)) begin
                            rd_d[16*h +: 16] = {pair_status(sel_head[k[1:0]][10:8]),
                                                sel_head[k[1:0]][7:0]};
                            k = k + BNW'(1);
                        end
                    end
                    rx_pop_n = k;
                end
                WIN_HOLD: if (bus_be[0]) begin
                    if (bus_we) begin
                        tx_push_data[0] = bus_wdata[7:0];
                        tx_push_n       = BNW'(1);
                        ovf_set         = (sel_tx_free == '0);
                    end else if (sel_rx_cnt != '0) begin
                        rd_d[7:0] = sel_head[0][7:0];
                        rx_pop_n  = BNW'(1);
                    end
                end
                WIN_LSR: if (!bus_we) begin
                    rd_d[7:0] = {ovf_q[ch_sel], 3'b000,
                                 (sel_rx_cnt != '0) ? sel_head[0][10:8] : 3'b000,
                                 sel_rx_cnt != '0};
                    ovf_clr   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign tx_out_vld  = tx_cnt[tx_out_ch] != '0;
    assign tx_out_data = tx_head[tx_out_ch][0];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic                 hit, rx_push, tx_pop;
            logic [0:0][RXW-1:0]  rx_wdata;

            assign hit      = (ch_sel == CH_W'(g));
            assign rx_push  = rx_in_vld && (rx_in_ch == CH_W'(g));
            assign tx_pop   = tx_out_rdy && (tx_out_ch == CH_W'(g));
            assign rx_wdata = {rx_in_err, rx_in_data};

            uart_byte_fifo #(.W(RXW), .DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(LANES)) rxq_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .push_n    (rx_push),
                .push_data (rx_wdata),
                .pop_n     (hit ? rx_pop_n : BNW'(0)),
                .head      (rx_head[g]),
                .count     (rx_cnt[g])
            );

            uart_byte_fifo #(.W(8), .DEPTH(DEPTH), .PUSH_LANES(LANES), .POP_LANES(1)) txq_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .push_n    (hit ? tx_push_n : BNW'(0)),
                .push_data (tx_push_data),
                .pop_n     (tx_pop),
                .head      (tx_head[g]),
                .count     (tx_cnt[g])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                 ovf_q[g] <= 1'b0;
                else if (hit && ovf_set)    ovf_q[g] <= 1'b1;
                else if (hit && ovf_clr)    ovf_q[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/uart_fifo_port_chk.sv
module uart_fifo_port_chk #(
    parameter int NCH    = 8,
    parameter int ADDR_W = 16,
    localparam int CH_W  = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic [31:0]       bus_rdata,
    input logic [NCH-1:0]    ovf_q
);
    localparam int HI = CH_W + 10;

    logic unmapped;
    assign unmapped = ((bus_addr >> HI) != '0) ||
                      ((bus_addr[9:8] == 2'b00) && (bus_addr[7:0] != 8'h00) &&
                       (bus_addr[7:0] != 8'h04));

    // R9
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req && !bus_ack));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R9
    write_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(bus_we)) |-> (bus_rdata == 32'h0));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(unmapped)) |-> (bus_rdata == 32'h0));

    // R6
    ovf_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ovf_q & ~$past(ovf_q))) |-> $past(bus_req && bus_we && !bus_ack));
endmodule

bind uart_fifo_port uart_fifo_port_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .ovf_q     (ovf_q)
);

// File: tb/uart_fifo_port_tb.sv
module uart_fifo_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        rx_in_vld = 1'b0;
    logic [2:0]  rx_in_ch = '0;
    logic [7:0]  rx_in_data = '0;
    logic [2:0]  rx_in_err = '0;
    logic [2:0]  tx_out_ch = '0;
    logic        tx_out_rdy = 1'b0;
    logic        tx_out_vld;
    logic [7:0]  tx_out_data;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic [10:0] rxm [8][64];
    logic [7:0]  txm [8][64];
    int rxh [8], rxc [8], txh [8], txc [8];
    bit ovfm [8];

    always #2.5 clk = ~clk;

    uart_fifo_port dut_i (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [15:0] a, input logic [3:0] be,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        chk({31'b0, bus_ack}, 32'h1, "R9 ack after accept");
        rd = bus_rdata;
        if (we) chk(rd, 32'h0, "R9 write rdata");
        @(negedge clk);
        chk({31'b0, bus_ack}, 32'h0, "R9 ack single cycle");
    endtask

    task automatic line_rx(input int ch, input logic [7:0] d, input logic [2:0] e);
        @(negedge clk);
        rx_in_vld = 1'b1; rx_in_ch = 3'(ch); rx_in_data = d; rx_in_err = e;
        @(negedge clk);
        rx_in_vld = 1'b0;
        if (rxc[ch] < 64) begin
            rxm[ch][(rxh[ch] + rxc[ch]) % 64] = {e, d};
            rxc[ch]++;
        end
    endtask

    function automatic logic [10:0] m_pop(input int ch);
        logic [10:0] v = rxm[ch][rxh[ch]];
        rxh[ch] = (rxh[ch] + 1) % 64;
        rxc[ch]--;
        return v;
    endfunction

    function automatic void m_tx(input int ch, input logic [7:0] b);
        if (txc[ch] < 64) begin
            txm[ch][(txh[ch] + txc[ch]) % 64] = b;
            txc[ch]++;
        end else ovfm[ch] = 1;
    endfunction

    task automatic fifo_rd(input int ch, input logic [3:0] be, input int off);
        logic [31:0] e = '0, r;
        for (int l = 0; l < 4; l++)
            if (be[l] && rxc[ch] > 0) e[8*l +: 8] = m_pop(ch)[7:0];
        bus(1'b0, 16'((4*ch + 1) * 256 + off), be, 32'h0, r);
        chk(r, e, "R2/R5 queue window read");
    endtask

    task automatic pair_rd(input int ch, input logic [3:0] be, input int off);
        logic [31:0] e = '0, r;
        logic [10:0] v;
        for (int h = 0; h < 2; h++)
            if (|be[2*h +: 2] && rxc[ch] > 0) begin
                v = m_pop(ch);
                e[16*h +: 16] = {4'b0, v[10:8], 1'b1, v[7:0]};
            end
        bus(1'b0, 16'((4*ch + 2) * 256 + off), be, 32'h0, r);
        chk(r, e, "R4/R5 paired window read");
    endtask

    task automatic lsr_rd(input int ch);
        logic [31:0] e, r;
        e = {24'h0, ovfm[ch], 3'b000,
             (rxc[ch] > 0) ? rxm[ch][rxh[ch]][10:8] : 3'b000, rxc[ch] > 0};
        ovfm[ch] = 0;
        bus(1'b0, 16'(ch * 1024 + 4), 4'hF, 32'h0, r);
        chk(r, e, "R8/R6 line status");
    endtask

    task automatic hold_rd(input int ch, input logic [3:0] be);
        logic [31:0] e = '0, r;
        if (be[0] && rxc[ch] > 0) e[7:0] = m_pop(ch)[7:0];
        bus(1'b0, 16'(ch * 1024), be, 32'h0, r);
        chk(r, e, "R7 holding read");
    endtask

    task automatic tx_drain(input int ch);
        while (txc[ch] > 0) begin
            @(negedge clk);
            tx_out_ch = 3'(ch);
            #1;
            chk({31'b0, tx_out_vld}, 32'h1, "R3 tx valid");
            chk({24'b0, tx_out_data}, {24'b0, txm[ch][txh[ch]]}, "R3 tx order");
            tx_out_rdy = 1'b1;
            @(negedge clk);
            tx_out_rdy = 1'b0;
            txh[ch] = (txh[ch] + 1) % 64;
            txc[ch]--;
        end
        #1;
        tx_out_ch = 3'(ch);
        #1;
        chk({31'b0, tx_out_vld}, 32'h0, "R3 tx drained");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int c = 0; c < 8; c++) begin
            rxh[c] = 0; rxc[c] = 0; txh[c] = 0; txc[c] = 0; ovfm[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: status words empty, no transmit data (R8, R1)
        chk({31'b0, bus_ack}, 32'h0, "R9 reset ack");
        for (int c = 0; c < 8; c++) lsr_rd(c);
        chk({31'b0, tx_out_vld}, 32'h0, "R3 reset tx empty");

        // Receive sweeps per channel (R1, R2, R4, R5, R7, R8, R11)
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < 20; i++) line_rx(c, 8'(c * 29 + i * 7), 3'((i + c) % 8));
            for (int be = 1; be < 16; be++) fifo_rd(c, 4'(be), (be * 4) % 256);
            lsr_rd(c);
            for (int i = 0; i < 7; i++) line_rx(c, 8'(c * 13 + i * 5 + 1), 3'(i % 8));
            lsr_rd(c);
            pair_rd(c, 4'b0011, 0);
            pair_rd(c, 4'b1100, 8);
            pair_rd(c, 4'b1111, 256 + 16);
            pair_rd(c, 4'b0001, 256);
            pair_rd(c, 4'b1111, 4);
            for (int i = 0; i < 2; i++) line_rx(c, 8'(c + 8'hA0 + i), 3'b101);
            hold_rd(c, 4'b1110);
            lsr_rd(c);
            hold_rd(c, 4'b0001);
            hold_rd(c, 4'b1111);
            hold_rd(c, 4'b0001);
            lsr_rd(c);
        end

        // Transmit sweeps per channel (R3, R7)
        for (int c = 0; c < 8; c++) begin
            for (int be = 1; be < 16; be++) begin
                logic [31:0] wd = 32'(c * 32'h01010101 + be * 32'h11223344);
                for (int l = 0; l < 4; l++) if (be[l]) m_tx(c, wd[8*l +: 8]);
                bus(1'b1, 16'((4*c + 1) * 256 + be * 8), 4'(be), wd, r);
            end
            m_tx(c, 8'(8'h5A + c));
            bus(1'b1, 16'(c * 1024), 4'b0001, {24'hFFFFFF, 8'(8'h5A + c)}, r);
            bus(1'b1, 16'(c * 1024), 4'b1110, 32'hDEADBEEF, r);
            tx_drain(c);
        end

        // Transmit overflow on channel 3 (R6)
        for (int w = 0; w < 17; w++) begin
            logic [31:0] wd = 32'(w * 32'h04040404 + 32'h03020100);
            for (int l = 0; l < 4; l++) m_tx(3, wd[8*l +: 8]);
            bus(1'b1, 16'h0D00, 4'hF, wd, r);
        end
        chk({31'b0, ovfm[3]}, 32'h1, "R6 model overflow");
        lsr_rd(3);
        lsr_rd(3);
        lsr_rd(2);
        tx_drain(3);

        // Receive queue full on channel 5 (R12, R5)
        for (int i = 0; i < 66; i++) line_rx(5, 8'(i + 3), 3'(i % 8));
        for (int w = 0; w < 17; w++) fifo_rd(5, 4'hF, 0);

        // Unmapped and read-only windows (R10, R11)
        line_rx(1, 8'h77, 3'b010);
        bus(1'b0, 16'h2500, 4'hF, 32'h0, r);
        chk(r, 32'h0, "R10 high address read");
        bus(1'b0, 16'h0408, 4'hF, 32'h0, r);
        chk(r, 32'h0, "R10 legacy hole read");
        bus(1'b1, 16'h0408, 4'hF, 32'hCAFEF00D, r);
        bus(1'b1, 16'h0600, 4'hF, 32'hCAFEF00D, r);
        bus(1'b1, 16'h0404, 4'hF, 32'hCAFEF00D, r);
        bus(1'b1, 16'h2500, 4'hF, 32'hCAFEF00D, r);
        tx_out_ch = 3'd1;
        #1;
        chk({31'b0, tx_out_vld}, 32'h0, "R10 ignored writes leave tx empty");
        fifo_rd(6, 4'hF, 0);
        lsr_rd(1);
        fifo_rd(1, 4'hF, 0);
        lsr_rd(1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule